// File: doc/BRIEF.md
# Completion Timeout Tracker

This block watches a single outstanding non-posted memory read that an endpoint has sent out. A request strobe with a tag arms a cycle counter. A completion strobe whose tag matches the held tag disarms it. If the counter reaches its limit before a matching completion arrives, the block records a completion timeout, raises the correctable-error-detected flag when reporting is enabled, and pulses a request for an error message.

Three registers sit on a simple word interface. The first is a 4-bit reporting enable control. The other two are status words: a device status word and an uncorrectable error status word. Both status words are write-one-to-clear, so software clears them by writing all ones.

The limit is set in clock cycles. At elaboration the limit is checked to lie strictly above 50 µs and strictly below 50 ms at the stated clock frequency.

Top module: `cpl_timeout_tracker`

## Requirements
- R1: After reset, `busy` and `err_msg_req` are 0 and every register address reads 0.
- R2: A write to address 0 stores `reg_wdata[3:0]` as the reporting enables. Bit 0 is the correctable enable. Address 0 reads these four bits in [3:0] and zero above them.
- R3: A request strobe seen while idle sets `busy` from the next cycle and latches its tag. A request strobe seen while `busy` is ignored: it neither restarts the count nor replaces the tag.
- R4: A completion with the held tag that arrives before the limit clears `busy` on the next cycle and sets no status bit. This holds for a completion 49 µs after its request.
- R5: A completion whose tag differs from the held tag is ignored, and the count continues.
- R6: With no matching completion, the timeout takes effect exactly TIMEOUT_CYCLES edges after the request edge, never earlier. On that edge `busy` falls and bit 14 of address 2 (completion timeout) is set, whatever the enables are.
- R7: On timeout, bit 0 of address 1 (correctable error detected) is set only if enable bit 0 is 1.
- R8: On timeout, `err_msg_req` is high for exactly one cycle, and only if enable bit 0 was 1.
- R9: Writing to address 1 or 2 clears each bit written as 1 and leaves each bit written as 0. Writing all ones clears the whole register.
- R10: When a clearing write and a new timeout event land on the same edge, the status bit ends set.
- R11: A completion arriving after expiry is dropped and changes no status bit. A matching completion on the very edge of expiry counts as late: the timeout is still logged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request issued this cycle |
| req_tag | input | TAG_W | Tag of the issued request |
| cpl_valid | input | 1 | Completion received this cycle |
| cpl_tag | input | TAG_W | Tag carried by the completion |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address (0 enables, 1 device status, 2 uncorrectable status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| busy | output | 1 | A request is being timed |
| err_msg_req | output | 1 | One-cycle error-message request on timeout |

## Verification
Two pairs of events can fall on the same edge. The first pair is a software clear of the uncorrectable status word and the expiry of the timer. The second pair is a matching completion and that same expiry. The bench counts edges from the request edge and drives both the all-ones write and the matching completion into the cycle that ends with the timeout edge. It then judges at the ports: the completion-timeout bit must read 1, and `busy` must be 0. The behavioural model, compared on every clock, applies clear-then-set and expiry-before-completion on its own.

// File: rtl/cto_pkg.sv
package cto_pkg;
  localparam int REG_W   = 32;
  localparam int CTO_BIT = 14;

  typedef logic [REG_W-1:0] reg_t;

  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_DEVSTS = 2'd1,
    SEL_UNCOR  = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  // clear-then-set: a new event wins over a same-cycle clear
  function automatic reg_t w1c_next(reg_t cur, reg_t clr, reg_t set);
    return (cur & ~clr) | set;
  endfunction

  // true on the last counted cycle before the limit
  function automatic logic limit_reached(logic [31:0] count, int unsigned limit);
    return count == (limit - 32'd1);
  endfunction
endpackage

// File: rtl/cto_timer.sv
module cto_timer #(
  parameter int TAG_W = 8,
  parameter int unsigned TIMEOUT_CYCLES = 1250000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             cpl_valid,
  input  logic [TAG_W-1:0] cpl_tag,
  output logic             pending,
  output logic             expire,
  output logic             cpl_hit,
  output logic [TAG_W-1:0] pend_tag
);
  localparam int CNT_W = $clog2(TIMEOUT_CYCLES);

  logic             pend_q;
  logic [TAG_W-1:0] tag_q;
  logic [CNT_W-1:0] cnt_q;
  logic             accept;

  assign expire   = pend_q && cto_pkg::limit_reached(32'(cnt_q), TIMEOUT_CYCLES);
  assign cpl_hit  = pend_q && cpl_valid && (cpl_tag == tag_q) && !expire;
  assign accept   = !pend_q && req_valid;
  assign pending  = pend_q;
  assign pend_tag = tag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      tag_q  <= '0;
      cnt_q  <= '0;
    end else if (expire || cpl_hit) begin
      pend_q <= 1'b0;
    end else if (accept) begin
      pend_q <= 1'b1;
      tag_q  <= req_tag;
      cnt_q  <= '0;
    end else if (pend_q) begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/cto_w1c_reg.sv
module cto_w1c_reg (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  cto_pkg::reg_t wdata,
  input  cto_pkg::reg_t set,
  output cto_pkg::reg_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= cto_pkg::w1c_next(q, wr_en ? wdata : '0, set);
  end
endmodule

// File: rtl/cto_regs.sv
module cto_regs (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  cto_pkg::reg_t wdata,
  input  logic          tmo,
  output cto_pkg::reg_t rdata,
  output logic          ce_en,
  output logic          cto_logged,
  output logic          msg_req
);
  import cto_pkg::*;

  localparam int N_STS = 2;

  logic [3:0] enable_q;
  reg_sel_e   sel;
  reg_t       sts_set [N_STS];
  reg_t       sts_q   [N_STS];
  logic       sts_wr  [N_STS];

  assign sel        = reg_sel_e'(addr);
  assign ce_en      = enable_q[0];
  assign sts_set[0] = (tmo && enable_q[0]) ? reg_t'(1) : '0;
  assign sts_set[1] = tmo ? (reg_t'(1) << CTO_BIT) : '0;
  assign sts_wr[0]  = wr_en && (sel == SEL_DEVSTS);
  assign sts_wr[1]  = wr_en && (sel == SEL_UNCOR);
  assign cto_logged = sts_q[1][CTO_BIT];

  for (genvar i = 0; i < N_STS; i++) begin : g_sts
    cto_w1c_reg u_sts (
      .clk  (clk),
      .rst_n(rst_n),
      .wr_en(sts_wr[i]),
      .wdata(wdata),
      .set  (sts_set[i]),
      .q    (sts_q[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      msg_req  <= 1'b0;
    end else begin
      if (wr_en && sel == SEL_ENABLE) enable_q <= wdata[3:0];
      msg_req <= tmo && enable_q[0];
    end
  end

  always_comb begin
    unique case (sel)
      SEL_ENABLE: rdata = {{(REG_W-4){1'b0}}, enable_q};
      SEL_DEVSTS: rdata = sts_q[0];
      SEL_UNCOR:  rdata = sts_q[1];
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/cpl_timeout_tracker.sv
module cpl_timeout_tracker #(
  parameter int unsigned CLK_MHZ        = 125,
  parameter int unsigned TIMEOUT_CYCLES = 10000 * CLK_MHZ,
  parameter int          TAG_W          = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             cpl_valid,
  input  logic [TAG_W-1:0] cpl_tag,
  input  logic             reg_wr_en,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             busy,
  output logic             err_msg_req
);
  localparam int unsigned MIN_CYC = 50 * CLK_MHZ;
  localparam int unsigned MAX_CYC = 50000 * CLK_MHZ;

  if (!(TIMEOUT_CYCLES > MIN_CYC && TIMEOUT_CYCLES < MAX_CYC)) begin : g_bad_limit
    $error("TIMEOUT_CYCLES outside the 50 us .. 50 ms window");
  end

  logic             tmo_event;
  logic             cpl_done;
  logic [TAG_W-1:0] pend_tag;
  logic             ce_en;
  logic             cto_logged;

  cto_timer #(.TAG_W(TAG_W), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_tag  (req_tag),
    .cpl_valid(cpl_valid),
    .cpl_tag  (cpl_tag),
    .pending  (busy),
    .expire   (tmo_event),
    .cpl_hit  (cpl_done),
    .pend_tag (pend_tag)
  );

  cto_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr_en),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .tmo       (tmo_event),
    .rdata     (reg_rdata),
    .ce_en     (ce_en),
    .cto_logged(cto_logged),
    .msg_req   (err_msg_req)
  );
endmodule

// File: rtl/cto_checker.sv
module cto_checker #(
  parameter int unsigned TIMEOUT_CYCLES = 1250000,
  parameter int          TAG_W          = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             cpl_valid,
  input logic [TAG_W-1:0] cpl_tag,
  input logic             reg_wr_en,
  input logic [1:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic             busy,
  input logic             err_msg_req,
  input logic             tmo_event,
  input logic             cpl_done,
  input logic [TAG_W-1:0] pend_tag,
  input logic             ce_en,
  input logic             cto_logged
);
  int unsigned age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  age <= 0;
    else if (!busy && req_valid) age <= 0;
    else if (busy)               age <= age + 1;
  end

  // R3
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> busy);

  // R4
  early_cpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cpl_valid && cpl_tag == pend_tag && !tmo_event) |=> (!busy && !err_msg_req));

  // R6
  no_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_event |-> (age == TIMEOUT_CYCLES - 1));

  // R6
  tmo_log_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_event |=> (cto_logged && !busy));

  // R8
  msg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_msg_req |=> !err_msg_req);

  // R8
  msg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_msg_req |-> ($past(ce_en) && $past(tmo_event)));

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == 2'd2 && reg_wdata[14] && !tmo_event) |=> !cto_logged);

  // R11
  late_cpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cpl_valid && !reg_wr_en) |=> ($stable(cto_logged) && !err_msg_req));

  // R5
  hit_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_done |-> (cpl_tag == pend_tag));
endmodule

bind cpl_timeout_tracker cto_checker #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES), .TAG_W(TAG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .cpl_valid  (cpl_valid),
  .cpl_tag    (cpl_tag),
  .reg_wr_en  (reg_wr_en),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .busy       (busy),
  .err_msg_req(err_msg_req),
  .tmo_event  (tmo_event),
  .cpl_done   (cpl_done),
  .pend_tag   (pend_tag),
  .ce_en      (ce_en),
  .cto_logged (cto_logged)
);

// File: tb/cpl_timeout_tracker_tb_top.sv
module cpl_timeout_tracker_tb_top;
  localparam int unsigned T    = 6300;
  localparam int unsigned T49  = 6125;
  localparam logic [31:0] CTO  = 32'h0000_4000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, cpl_valid = 1'b0, reg_wr_en = 1'b0;
  logic [7:0]  req_tag = '0, cpl_tag = '0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        busy, err_msg_req;

  int n_chk = 0, n_fail = 0, edge_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  cpl_timeout_tracker #(.CLK_MHZ(125), .TIMEOUT_CYCLES(T), .TAG_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tag(req_tag),
    .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .err_msg_req(err_msg_req));

  // behavioural model
  bit m_busy, m_msg, m_dsts, m_cto;
  int m_age;
  logic [7:0] m_tag;
  logic [3:0] m_en;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_msg = 0; m_dsts = 0; m_cto = 0; m_age = 0; m_tag = 0; m_en = 0;
    end else begin
      automatic logic [3:0] en_old = m_en;
      automatic bit fire = m_busy && (m_age + 1 == int'(T));
      m_msg = fire && en_old[0];
      if (fire) m_busy = 0;
      else if (m_busy && cpl_valid && cpl_tag == m_tag) m_busy = 0;
      else if (m_busy) m_age++;
      else if (req_valid) begin m_busy = 1; m_age = 0; m_tag = req_tag; end
      if (reg_wr_en && reg_addr == 0) m_en = reg_wdata[3:0];
      if (reg_wr_en && reg_addr == 1 && reg_wdata[0]) m_dsts = 0;
      if (reg_wr_en && reg_addr == 2 && reg_wdata[14]) m_cto = 0;
      if (fire && en_old[0]) m_dsts = 1;
      if (fire) m_cto = 1;
    end
  end

  function automatic logic [31:0] m_read(logic [1:0] a);
    case (a)
      2'd0: return {28'd0, m_en};
      2'd1: return {31'd0, m_dsts};
      2'd2: return m_cto ? CTO : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R3 model busy", 32'(busy), 32'(m_busy));
    chk("R8 model msg", 32'(err_msg_req), 32'(m_msg));
    chk("R9 model rdata", reg_rdata, m_read(reg_addr));
  end

  task automatic wait_edge(int e);
    while (edge_cnt < e) begin @(negedge clk); #1; end
  endtask

  task automatic rd(logic [1:0] a, logic [31:0] exp, string rq);
    reg_addr = a; #1;
    chk(rq, reg_rdata, exp);
  endtask

  task automatic wr_at(int e, logic [1:0] a, logic [31:0] d);
    wait_edge(e - 1);
    reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    wait_edge(e);
    reg_wr_en = 0;
  endtask

  task automatic req_at(int e, logic [7:0] t);
    wait_edge(e - 1); req_valid = 1; req_tag = t;
    wait_edge(e);     req_valid = 0;
  endtask

  task automatic cpl_at(int e, logic [7:0] t);
    wait_edge(e - 1); cpl_valid = 1; cpl_tag = t;
    wait_edge(e);     cpl_valid = 0;
  endtask

  initial begin
    int e0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    // R1
    chk("R1 busy", 32'(busy), 0);
    chk("R1 msg", 32'(err_msg_req), 0);
    for (int a = 0; a < 4; a++) rd(2'(a), 0, "R1");
    // R2
    wr_at(edge_cnt + 1, 0, 32'hFFFF_FFFF);
    rd(0, 32'h0000_000F, "R2");
    // R3 / R4: completion at 49 us with matching tag
    e0 = edge_cnt + 2;
    req_at(e0, 8'd5);
    chk("R3 busy after request", 32'(busy), 1);
    cpl_at(e0 + int'(T49), 8'd5);
    chk("R4 busy after completion", 32'(busy), 0);
    rd(1, 0, "R4"); rd(2, 0, "R4");
    // R3 / R5 / R6 / R7 / R8
    e0 = edge_cnt + 2;
    req_at(e0, 8'd3);
    req_at(e0 + 5, 8'd9);
    cpl_at(e0 + 10, 8'd9);
    chk("R5 busy after foreign tag", 32'(busy), 1);
    wait_edge(e0 + int'(T) - 1);
    chk("R6 not early", 32'(busy), 1);
    chk("R8 no pulse before limit", 32'(err_msg_req), 0);
    wait_edge(e0 + int'(T));
    chk("R6 busy at limit", 32'(busy), 0);
    chk("R8 pulse at limit", 32'(err_msg_req), 1);
    rd(2, CTO, "R6"); rd(1, 1, "R7");
    wait_edge(e0 + int'(T) + 1);
    chk("R8 single cycle", 32'(err_msg_req), 0);
    // R9
    wr_at(e0 + int'(T) + 3, 2, 32'h0);
    rd(2, CTO, "R9 zero write keeps");
    wr_at(e0 + int'(T) + 5, 2, 32'hFFFF_FFFF);
    wr_at(e0 + int'(T) + 6, 1, 32'hFFFF_FFFF);
    rd(1, 0, "R9"); rd(2, 0, "R9");
    // R11 late completion
    cpl_at(e0 + int'(T) + 8, 8'd3);
    wait_edge(e0 + int'(T) + 9);
    rd(1, 0, "R11"); rd(2, 0, "R11");
    chk("R11 msg", 32'(err_msg_req), 0);
    // R7 / R8 with correctable enable off
    wr_at(edge_cnt + 1, 0, 32'h0000_000E);
    e0 = edge_cnt + 2;
    req_at(e0, 8'd1);
    wait_edge(e0 + int'(T));
    chk("R6 busy gated", 32'(busy), 0);
    chk("R8 gated off", 32'(err_msg_req), 0);
    rd(1, 0, "R7 gated off"); rd(2, CTO, "R6 logged ungated");
    wr_at(edge_cnt + 1, 2, 32'hFFFF_FFFF);
    wr_at(edge_cnt + 1, 0, 32'h0000_000F);
    // R10 / R11 collisions on the expiry edge
    e0 = edge_cnt + 2;
    req_at(e0, 8'd2);
    wait_edge(e0 + int'(T) - 1);
    reg_wr_en = 1; reg_addr = 2; reg_wdata = 32'hFFFF_FFFF;
    cpl_valid = 1; cpl_tag = 8'd2;
    wait_edge(e0 + int'(T));
    reg_wr_en = 0; cpl_valid = 0;
    chk("R11 expiry beats completion", 32'(busy), 0);
    chk("R8 pulse on collision", 32'(err_msg_req), 1);
    rd(2, CTO, "R10 set wins");
    rd(1, 1, "R7");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule